// File: doc/BRIEF.md
# Serial Pixel Stream Transmitter

The block sends a stream of pixels out on one serial data pin, one bit per clock, most significant bit first. It asks an upstream frame source for each pixel with a one-cycle request and takes the pixel byte on the same clock edge. Around the data it drives a one-cycle bit-sync strobe on the first bit of each pixel, a row envelope that covers every bit of a row, and a frame envelope. Rows are separated by a parameterized horizontal blanking interval in which the data pin, the strobe and the row envelope are low.

Two modes share the frame pin, which is split into input, output and output-enable signals. In video mode the block runs freely. It starts a frame straight after reset, drives the frame envelope, and waits one blanking interval after each frame before starting the next one. In snapshot mode the block releases the frame pin and uses it as a trigger. A frame starts only when the pin has been high for two consecutive clocks while the block is idle. After the frame the block goes back to idle. The enables of the six unused parallel data pins are held low in both modes, so those pins stay at high impedance. The mode input is expected to change only while reset is asserted.

Top module: `sps_serial_tx`

## Requirements
- R1: Each pixel byte is sent on `ser_out` over 8 consecutive cycles, bit 7 first and bit 0 last. The byte sent is the `pix_data` value present in the cycle where `pix_req` was high, and pixels go out in the order they were requested.
- R2: `bit_sync` is high for exactly one cycle per pixel, in the cycle that carries bit 7.
- R3: `row_env` is high for exactly COLS×8 consecutive cycles per row. Between rows it is low for exactly HBL cycles, and during those cycles `ser_out` and `bit_sync` are low.
- R4: In video mode (`snap_mode`=0), `frame_oe` is 1. `frame_out` rises with the first bit of a frame and falls after the last bit of its final row. It then stays low for HBL cycles, and the next frame starts. The first frame begins with its first bit in the second cycle after reset is released.
- R5: `pix_req` is high exactly in the cycle before each pixel's bit 7 appears, and in no other cycle.
- R6: In snapshot mode (`snap_mode`=1), `frame_oe` and `frame_out` are 0. A frame starts only when `frame_in` has been high in two consecutive idle cycles. `pix_req` goes high in the second of those cycles, and bit 7 of the first pixel appears in the next cycle.
- R7: In snapshot mode, `frame_in` is ignored while a frame is in progress. After the last bit of the frame the block returns to idle, and the high-cycle count starts again from zero.
- R8: `par_oe` (the enables of the six unused parallel data pins) is always 0, so those pins are never driven.
- R9: A synchronous active-high `rst` puts the block in idle with `ser_out`, `bit_sync`, `row_env`, `frame_out` and `pix_req` low, and clears any partial trigger count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| snap_mode | input | 1 | 0 = free-running video, 1 = triggered snapshot |
| pix_data | input | PIX_W | Pixel byte from the source, taken at the edge that ends a `pix_req` cycle |
| pix_req | output | 1 | Request for the next pixel |
| frame_in | input | 1 | Frame pin as seen from outside (snapshot trigger) |
| frame_out | output | 1 | Frame envelope driven on the frame pin in video mode |
| frame_oe | output | 1 | Drive enable for the frame pin (high in video mode) |
| ser_out | output | 1 | Serial pixel data |
| bit_sync | output | 1 | One-cycle strobe on bit 7 of each pixel |
| row_env | output | 1 | Row envelope |
| par_oe | output | PAR_UNUSED | Drive enables of the unused parallel data pins |

## Verification
The bench builds the block with COLS=4, ROWS=3 and HBL=3, so a video frame period is 105 cycles. This lets the run cover the wrap from one video frame into the next, several snapshot frames, and a trigger held high across the end of a frame, all within a few hundred cycles. The small blanking interval also puts pixel requests from the end of a blanking interval and from the end of a frame gap close together, where an off-by-one in the counters would show at once. A reset in the middle of a video frame, and a reset that lands on a half-counted trigger, are both checked against the cycle model.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LINE   = 2'd1,
    ST_HBLANK = 2'd2,
    ST_GAP    = 2'd3
  } sps_state_t;

  // width of a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // cycles for which the row envelope is high
  function automatic int row_cycles(input int cols, input int pix_w);
    return cols * pix_w;
  endfunction

  // cycles from the first bit of a frame to the last bit of its final row
  function automatic int frame_active_cycles(input int cols, input int rows,
                                             input int pix_w, input int hbl);
    return rows * (cols * pix_w + hbl) - hbl;
  endfunction

endpackage

// File: rtl/sps_trigger.sv
`timescale 1ns/1ps
module sps_trigger
  import sps_pkg::*;
#(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pin_in,
  output logic fire
);
  localparam int CW = cnt_width(HOLD);
  localparam logic [CW-1:0] NEED = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  // counts earlier high cycles while armed; restarts whenever disarmed
  always_ff @(posedge clk) begin
    if (rst || !arm || !pin_in)  cnt_q <= '0;
    else if (cnt_q < NEED)       cnt_q <= cnt_q + CW'(1);
  end

  assign fire = !rst && arm && pin_in && (cnt_q >= NEED);

  // R6: a fire needs the pin high now and on the cycle before
  assert_fire_needs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    fire |-> (pin_in && $past(pin_in)));

endmodule

// File: rtl/sps_shifter.sv
`timescale 1ns/1ps
module sps_shifter #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIX_W-1:0] din,
  output logic             msb
);
  logic [PIX_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= din;
    else           sh_q <= {sh_q[PIX_W-2:0], 1'b0};
  end

  assign msb = sh_q[PIX_W-1];

endmodule

// File: rtl/sps_sequencer.sv
`timescale 1ns/1ps
module sps_sequencer
  import sps_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int ROWS  = 100,
  parameter int HBL   = 8,
  parameter int PIX_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic video,
  input  logic fire,
  output logic load,
  output logic in_line,
  output logic in_frame,
  output logic first_bit,
  output logic idle
);
  localparam int BW = cnt_width(PIX_W);
  localparam int CW = cnt_width(COLS);
  localparam int RW = cnt_width(ROWS);
  localparam int HW = cnt_width(HBL);
  localparam logic [BW-1:0] BIT_LAST = BW'(PIX_W - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [HW-1:0] BLK_LAST = HW'(HBL - 1);

  sps_state_t st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic [HW-1:0] blk_q, blk_d;

  // named events
  logic start_ev, bit_end, row_end, frame_end, blk_end;

  always_comb begin
    start_ev  = !rst && (st_q == ST_IDLE) && (video || fire);
    bit_end   = (st_q == ST_LINE) && (bit_q == BIT_LAST);
    row_end   = bit_end && (col_q == COL_LAST);
    frame_end = row_end && (row_q == ROW_LAST);
    blk_end   = ((st_q == ST_HBLANK) || (st_q == ST_GAP)) && (blk_q == BLK_LAST);
  end

  assign load = start_ev || (bit_end && !row_end) || blk_end;

  always_comb begin
    st_d  = st_q;
    bit_d = bit_q;
    col_d = col_q;
    row_d = row_q;
    blk_d = blk_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ev) begin
          st_d  = ST_LINE;
          bit_d = '0;
          col_d = '0;
          row_d = '0;
        end
      end
      ST_LINE: begin
        bit_d = bit_q + BW'(1);
        if (bit_end) begin
          bit_d = '0;
          if (row_end) begin
            blk_d = '0;
            if (frame_end) st_d = video ? ST_GAP : ST_IDLE;
            else           st_d = ST_HBLANK;
          end else begin
            col_d = col_q + CW'(1);
          end
        end
      end
      ST_HBLANK: begin
        blk_d = blk_q + HW'(1);
        if (blk_end) begin
          st_d  = ST_LINE;
          row_d = row_q + RW'(1);
          col_d = '0;
          bit_d = '0;
        end
      end
      ST_GAP: begin
        blk_d = blk_q + HW'(1);
        if (blk_end) begin
          st_d  = ST_LINE;
          row_d = '0;
          col_d = '0;
          bit_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      col_q <= '0;
      row_q <= '0;
      blk_q <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      col_q <= col_d;
      row_q <= row_d;
      blk_q <= blk_d;
    end
  end

  assign in_line   = (st_q == ST_LINE);
  assign in_frame  = (st_q == ST_LINE) || (st_q == ST_HBLANK);
  assign first_bit = (st_q == ST_LINE) && (bit_q == '0);
  assign idle      = (st_q == ST_IDLE);

  // R7: snapshot end of frame lands in idle on the next cycle
  assert_snap_back_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !video) |=> idle);

endmodule

// File: rtl/sps_serial_tx.sv
`timescale 1ns/1ps
module sps_serial_tx
  import sps_pkg::*;
#(
  parameter int COLS       = 128,
  parameter int ROWS       = 100,
  parameter int HBL        = 8,
  parameter int PIX_W      = 8,
  parameter int TRIG_HOLD  = 2,
  parameter int PAR_UNUSED = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  snap_mode,
  input  logic [PIX_W-1:0]      pix_data,
  output logic                  pix_req,
  input  logic                  frame_in,
  output logic                  frame_out,
  output logic                  frame_oe,
  output logic                  ser_out,
  output logic                  bit_sync,
  output logic                  row_env,
  output logic [PAR_UNUSED-1:0] par_oe
);
  localparam int ROW_CYC = row_cycles(COLS, PIX_W);
  localparam int FRM_CYC = frame_active_cycles(COLS, ROWS, PIX_W, HBL);
  localparam int RLW     = cnt_width(ROW_CYC + 2);
  localparam int FLW     = cnt_width(FRM_CYC + 2);

  logic video;
  logic trig_fire;
  logic load, in_line, in_frame, first_bit, idle;
  logic shift_msb;

  assign video = !snap_mode;

  sps_trigger #(.HOLD(TRIG_HOLD)) u_trig (
    .clk    (clk),
    .rst    (rst),
    .arm    (idle && snap_mode),
    .pin_in (frame_in),
    .fire   (trig_fire)
  );

  sps_sequencer #(.COLS(COLS), .ROWS(ROWS), .HBL(HBL), .PIX_W(PIX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .video     (video),
    .fire      (trig_fire),
    .load      (load),
    .in_line   (in_line),
    .in_frame  (in_frame),
    .first_bit (first_bit),
    .idle      (idle)
  );

  sps_shifter #(.PIX_W(PIX_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (pix_data),
    .msb  (shift_msb)
  );

  assign pix_req   = load;
  assign ser_out   = in_line && shift_msb;
  assign bit_sync  = first_bit;
  assign row_env   = in_line;
  assign frame_out = video && in_frame;
  assign frame_oe  = video;
  assign par_oe    = '0;

  // run-length counters for the window checks
  logic [RLW-1:0] row_run_q;
  logic [FLW-1:0] frm_run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      row_run_q <= '0;
      frm_run_q <= '0;
    end else begin
      row_run_q <= row_env   ? row_run_q + RLW'(1) : '0;
      frm_run_q <= frame_out ? frm_run_q + FLW'(1) : '0;
    end
  end

  // R2: strobe lasts one cycle
  assert_bsync_single_R2: assert property (@(posedge clk) disable iff (rst)
    bit_sync |=> !bit_sync);

  // R3: strobe only inside a row
  assert_bsync_in_row_R3: assert property (@(posedge clk) disable iff (rst)
    bit_sync |-> row_env);

  // R3: each row lasts exactly COLS*PIX_W cycles
  assert_row_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(row_env) |-> (row_run_q == RLW'(ROW_CYC)));

  // R4: frame envelope lasts from first to last bit of the frame
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_out) |-> (frm_run_q == FLW'(FRM_CYC)));

  // R5: a request is followed by a pixel MSB
  assert_req_then_msb_R5: assert property (@(posedge clk) disable iff (rst)
    pix_req |=> bit_sync);

  // R7: no trigger accepted while a row is being sent
  assert_no_trig_busy_R7: assert property (@(posedge clk) disable iff (rst)
    row_env |-> !trig_fire);

  // R4: in video mode every row sits inside the frame envelope
  assert_row_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    (row_env && !snap_mode) |-> frame_out);

endmodule

// File: tb/tb_sps_serial_tx.sv
`timescale 1ns/1ps
module tb_sps_serial_tx;
  localparam int COLS = 4;
  localparam int ROWS = 3;
  localparam int HBL  = 3;
  localparam int W    = 8;
  localparam int L    = COLS * W;
  localparam int SEG  = L + HBL;
  localparam int PER  = ROWS * SEG;
  localparam int AEND = PER - HBL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snap_mode = 1'b0;
  logic [W-1:0] pix_data;
  logic pix_req, frame_in, frame_out, frame_oe, ser_out, bit_sync, row_env;
  logic [5:0] par_oe;

  always #2 clk = ~clk;

  sps_serial_tx #(.COLS(COLS), .ROWS(ROWS), .HBL(HBL), .PIX_W(W)) dut (
    .clk(clk), .rst(rst), .snap_mode(snap_mode), .pix_data(pix_data),
    .pix_req(pix_req), .frame_in(frame_in), .frame_out(frame_out),
    .frame_oe(frame_oe), .ser_out(ser_out), .bit_sync(bit_sync),
    .row_env(row_env), .par_oe(par_oe)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [W-1:0] pix_f(input int n);
    return W'((n * 73 + 29) & 255);
  endfunction

  task automatic chk(input string tag, input string name,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  // source driver
  logic drv_req = 1'b0;
  logic drv_rst = 1'b1;
  int   k = 0;
  initial pix_data = pix_f(0);
  initial frame_in = 1'b0;
  always @(posedge clk) begin
    #1;
    if (drv_rst) begin
      k = 0;
      pix_data = pix_f(0);
    end else if (drv_req) begin
      k++;
      pix_data = pix_f(k);
    end
  end

  // reference model, one step per clock
  bit m_run = 0, m_go = 0, first = 1, rst_prev = 1, fin_prev = 0, row_prev = 0;
  int m_p = 0, m_hi = 0, m_next = 0, m_cur = 0, snap_rows = 0;

  always @(negedge clk) begin
    logic e_ser, e_bs, e_row, e_frm, e_req;
    int q, nxt;
    if (rst) begin
      if (rst_prev) begin   // R9
        chk("R9", "ser_out",   ser_out,   0);
        chk("R9", "bit_sync",  bit_sync,  0);
        chk("R9", "row_env",   row_env,   0);
        chk("R9", "frame_out", frame_out, 0);
        chk("R9", "pix_req",   pix_req,   0);
      end
      m_run = 0; m_go = 0; m_p = 0; m_hi = 0; m_next = 0; m_cur = 0;
      first = 1; drv_req = 0; drv_rst = 1;
    end else begin
      drv_rst = 0;
      if (!first) begin
        if (m_run) begin
          m_p++;
          if (!snap_mode && m_p == PER) m_p = 0;
          if (snap_mode && m_p == AEND) begin m_run = 0; m_hi = 0; end
        end else if (m_go) begin
          m_run = 1; m_p = 0; m_hi = 0;
        end else begin
          m_hi = (snap_mode && fin_prev) ? 1 : 0;
        end
        if (m_run && (m_p % SEG) < L && (m_p % SEG) % W == 0) begin
          m_cur = m_next; m_next++;
        end
      end
      first = 0;
      if (m_run) begin
        q     = m_p % SEG;
        e_row = (q < L);
        e_bs  = e_row && (q % W == 0);
        e_ser = e_row ? pix_f(m_cur)[W-1-(q % W)] : 1'b0;
        e_frm = !snap_mode && (m_p < AEND);
        nxt   = m_p + 1;
        if (!snap_mode && nxt == PER) nxt = 0;
        e_req = (snap_mode ? (nxt < AEND) : 1'b1) && ((nxt % SEG) < L) && ((nxt % SEG) % W == 0);
        m_go  = 0;
      end else begin
        e_row = 0; e_bs = 0; e_ser = 0; e_frm = 0;
        m_go  = snap_mode ? (frame_in && m_hi == 1) : 1'b1;
        e_req = m_go;
      end
      chk("R1", "ser_out",  ser_out,  e_ser);
      chk("R2", "bit_sync", bit_sync, e_bs);
      chk("R3", "row_env",  row_env,  e_row);
      chk(snap_mode ? "R6" : "R4", "frame_out", frame_out, e_frm);
      chk(snap_mode ? "R6" : "R4", "frame_oe",  frame_oe,  !snap_mode);
      chk(snap_mode ? "R7" : "R5", "pix_req",   pix_req,   e_req);
      chk("R8", "par_oe", {2'b00, par_oe}, 8'h00);
      drv_req = e_req;
      if (snap_mode && row_env && !row_prev) snap_rows++;
    end
    row_prev = row_env;
    fin_prev = frame_in;
    rst_prev = rst;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1; snap_mode = 0; frame_in = 0;
    tick(3);
    rst = 0;
    tick(260);                              // R4 R5 video frames and wrap
    rst = 1; snap_mode = 1; tick(2);        // R9 reset mid-frame
    rst = 0; tick(5);
    frame_in = 1; tick(1); frame_in = 0;    // R6 single pulse ignored
    tick(6);
    frame_in = 1; tick(2); frame_in = 0;    // R6 valid trigger
    tick(20);
    frame_in = 1; tick(5); frame_in = 0;    // R7 ignored during frame
    tick(100);
    frame_in = 1; tick(1);                  // R9 partial count then reset
    rst = 1; tick(1); rst = 0;
    tick(1); frame_in = 0; tick(5);
    frame_in = 1; tick(115); frame_in = 0;  // R7 held across frame end
    tick(110);
    chk("R7", "snapshot rows", 8'(snap_rows), 8'(3 * ROWS));
    chk("R6", "idle frame_oe", frame_oe, 0);
    summary();
    $finish;
  end

endmodule